// File: doc/BRIEF.md
# Debounced Keypad Matrix Scanner

This block scans a four-by-four grid of push switches. It pulls one row line low at a time and leaves the others high. It reads the four column lines, which are pulled up and go low when a switch on the pulled-down row is closed. For every switch it keeps a debounced pressed or released state, and it presents all sixteen states at once as a bit map. The surrounding logic can read the whole map at any time. When it only needs to know that something changed, it can wait for a single-cycle strobe.

Timing comes from a clock prescaler. The prescaler produces a tick every `TICK_DIV` clocks. Each row stays low for `DWELL_TICKS` ticks so that its contacts can settle, and the columns are read on the final clock of that window. After the last row, every row line rests high for `GAP_TICKS` ticks before the next scan begins. With the default values and a 50 MHz clock, a row stays low for 10 ms and the rest period between scans is 5 ms.

Each key has its own run counter. A key's stored state flips only after `DEBOUNCE` samples in a row (one sample per scan) that disagree with it. The default is 3, and the parameter accepts values from 1 to 12 for noisy switches. The column inputs pass through a two-flop synchronizer before they are sampled.

Top module: `keypad_scanner`

## Requirements
- R1: At most one row output is low at any time. The row that is being scanned is driven low and all other rows are high.
- R2: A scan drives row 0, row 1, row 2 and row 3 low in that order. All rows then return high for a rest period before the next scan starts with row 0.
- R3: Each row stays low for exactly `DWELL_TICKS*TICK_DIV` clock cycles.
- R4: The all-high rest period between scans lasts exactly `GAP_TICKS*TICK_DIV` clock cycles.
- R5: Bit `row*4+col` of `key_map` holds the state of the key at that row and column: 1 means pressed and 0 means released. A column input that reads 0 while its row is low counts as a pressed sample.
- R6: A released key becomes pressed in `key_map` at the end of the `DEBOUNCE`-th consecutive scan in which it is seen pressed. It is unchanged after fewer such scans.
- R7: One sample that agrees with a key's stored state clears that key's run, so a press interrupted by a single released scan needs a fresh run of `DEBOUNCE` scans.
- R8: `change_stb` is high for exactly one cycle, in the first cycle of the rest period, after any scan that changed at least one key's state. It stays low after scans that change nothing.
- R9: After reset all rows are high, `key_map` is all zeros and `change_stb` is low.
- R10: A pressed key returns to released only after `DEBOUNCE` consecutive released scans.
- R11: Several keys pressed together are tracked independently, and keys changing in both directions in the same scan all update together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| col_n_in | input | 4 | Column lines, pulled up; a low bit means a closed switch on the active row |
| row_n_out | output | 4 | Row drives, active low, one at a time |
| key_map | output | 16 | Debounced key states, bit `row*4+col`, 1 = pressed |
| change_stb | output | 1 | One-cycle pulse after a scan that changed any key |

## Verification
The bench models the switch matrix itself: each column line is computed from the bench's pressed-key set and the row the design is currently pulling low. This model exposes a swapped row order or a wrong bit index as a wrong bit in the map. Each of the sixteen keys is pressed and released on its own, and the map is checked after every scan. An off-by-one threshold would set the bit one scan early or late, and a missed counter clear would accept a bounced press. Multi-key patterns and a full inversion of a pattern check that keys do not interfere with each other, and that a scan with no change leaves the strobe low. The cycle lengths of each row and of the rest period are measured, so an off-by-one in the tick counter or the prescaler shows up as a wrong length.

// File: rtl/keypad_scan_pkg.sv
// Shared types for the keypad scanner.
// Assumes: nothing beyond IEEE 1800-2017.
package keypad_scan_pkg;

    // Phase of the scan sequencer: a row is being driven, or all rows rest high.
    typedef enum logic {
        PH_ROW = 1'b0,
        PH_GAP = 1'b1
    } scan_phase_e;

endpackage

// File: rtl/kp_tick_gen.sv
// Clock prescaler: emits a one-cycle tick every DIV clocks.
// Assumes: DIV >= 1; DIV == 1 makes the tick permanently high.
module kp_tick_gen #(
    parameter int DIV = 50000
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);

    generate
        if (DIV == 1) begin : g_every_clock
            assign tick = 1'b1;
        end else begin : g_divided
            localparam int CW = $clog2(DIV);
            logic [CW-1:0] cnt;

            // Count clocks and wrap at DIV-1.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    cnt <= '0;
                else if (cnt == CW'(DIV - 1))
                    cnt <= '0;
                else
                    cnt <= cnt + 1'b1;
            end

            assign tick = (cnt == CW'(DIV - 1));
        end
    endgenerate

endmodule

// File: rtl/kp_row_sequencer.sv
// Row sequencer: steps an active-low drive through the rows, holding each
// for DWELL_TICKS ticks, then rests all rows high for GAP_TICKS ticks.
// Flags the sample point (last clock of a row's dwell) and the scan end.
// Assumes: ROWS >= 2, DWELL_TICKS >= 1, GAP_TICKS >= 1.
module kp_row_sequencer
    import keypad_scan_pkg::*;
#(
    parameter int ROWS        = 4,
    parameter int DWELL_TICKS = 10,
    parameter int GAP_TICKS   = 5,
    localparam int RW   = $clog2(ROWS),
    localparam int TMAX = (DWELL_TICKS > GAP_TICKS) ? DWELL_TICKS : GAP_TICKS,
    localparam int TCW  = $clog2(TMAX + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick,
    output logic [ROWS-1:0] row_n,
    output logic            sample_en,
    output logic [RW-1:0]   sample_row,
    output logic            scan_end
);

    scan_phase_e    phase;
    logic [RW-1:0]  row_idx;
    logic [TCW-1:0] tcnt;
    logic           dwell_done;
    logic           gap_done;

    assign dwell_done = tick && (phase == PH_ROW) && (tcnt == TCW'(DWELL_TICKS - 1));
    assign gap_done   = tick && (phase == PH_GAP) && (tcnt == TCW'(GAP_TICKS - 1));

    // Advance the tick count, the row index and the phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase   <= PH_GAP;
            row_idx <= '0;
            tcnt    <= '0;
        end else if (dwell_done) begin
            tcnt <= '0;
            if (row_idx == RW'(ROWS - 1))
                phase <= PH_GAP;
            else
                row_idx <= row_idx + 1'b1;
        end else if (gap_done) begin
            tcnt    <= '0;
            phase   <= PH_ROW;
            row_idx <= '0;
        end else if (tick) begin
            tcnt <= tcnt + 1'b1;
        end
    end

    // Decode the active-low row drive from phase and index.
    always_comb begin
        row_n = '1;
        if (phase == PH_ROW)
            row_n[row_idx] = 1'b0;
    end

    assign sample_en  = dwell_done;
    assign sample_row = row_idx;
    assign scan_end   = dwell_done && (row_idx == RW'(ROWS - 1));

endmodule

// File: rtl/kp_key_cell.sv
// One key's debouncer: flips its stored state after THRESH consecutive
// samples that disagree with it; an agreeing sample clears the run.
// Assumes: sample_en is high for one clock per sample of this key.
module kp_key_cell #(
    parameter int THRESH = 3,
    localparam int CW = $clog2(THRESH + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sample_en,
    input  logic raw_pressed,
    output logic state,
    output logic flip
);

    logic [CW-1:0] run;

    assign flip = sample_en && (raw_pressed != state) && (run == CW'(THRESH - 1));

    // Track the disagreeing run and commit the new state at the threshold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= 1'b0;
            run   <= '0;
        end else if (sample_en) begin
            if (raw_pressed == state) begin
                run <= '0;
            end else if (run == CW'(THRESH - 1)) begin
                state <= raw_pressed;
                run   <= '0;
            end else begin
                run <= run + 1'b1;
            end
        end
    end

endmodule

// File: rtl/keypad_scanner.sv
// Debounced keypad matrix scanner (top). Drives active-low rows, samples
// synchronized active-low columns, debounces each key and pulses a strobe
// at the end of any scan that changed a key.
// Assumes: columns are pulled up externally; DEBOUNCE in 1..12.
module keypad_scanner #(
    parameter int ROWS        = 4,
    parameter int COLS        = 4,
    parameter int TICK_DIV    = 50000,
    parameter int DWELL_TICKS = 10,
    parameter int GAP_TICKS   = 5,
    parameter int DEBOUNCE    = 3,
    localparam int KEYS = ROWS * COLS,
    localparam int RW   = $clog2(ROWS)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [COLS-1:0] col_n_in,
    output logic [ROWS-1:0] row_n_out,
    output logic [KEYS-1:0] key_map,
    output logic            change_stb
);

    generate
        if (DEBOUNCE < 1 || DEBOUNCE > 12) begin : g_bad_debounce
            $error("keypad_scanner: DEBOUNCE must lie in 1..12");
        end
    endgenerate

    logic            tick;
    logic            sample_en;
    logic [RW-1:0]   sample_row;
    logic            scan_end;
    logic [COLS-1:0] col_meta;
    logic [COLS-1:0] col_sync;
    logic [KEYS-1:0] flips;
    logic            seen_change;

    kp_tick_gen #(.DIV(TICK_DIV)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    kp_row_sequencer #(
        .ROWS        (ROWS),
        .DWELL_TICKS (DWELL_TICKS),
        .GAP_TICKS   (GAP_TICKS)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .row_n      (row_n_out),
        .sample_en  (sample_en),
        .sample_row (sample_row),
        .scan_end   (scan_end)
    );

    // Two-flop synchronizer on the column lines (idle high = released).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            col_meta <= '1;
            col_sync <= '1;
        end else begin
            col_meta <= col_n_in;
            col_sync <= col_meta;
        end
    end

    generate
        for (genvar r = 0; r < ROWS; r++) begin : g_row
            for (genvar c = 0; c < COLS; c++) begin : g_col
                kp_key_cell #(.THRESH(DEBOUNCE)) u_cell (
                    .clk         (clk),
                    .rst_n       (rst_n),
                    .sample_en   (sample_en && (sample_row == RW'(r))),
                    .raw_pressed (!col_sync[c]),
                    .state       (key_map[r*COLS + c]),
                    .flip        (flips[r*COLS + c])
                );
            end
        end
    endgenerate

    // Collect changes over a scan and pulse the strobe when it ends.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_change <= 1'b0;
            change_stb  <= 1'b0;
        end else if (scan_end) begin
            change_stb  <= seen_change || (|flips);
            seen_change <= 1'b0;
        end else begin
            change_stb  <= 1'b0;
            seen_change <= seen_change || (|flips);
        end
    end

endmodule

// File: rtl/kp_scan_checker.sv
// Assertion checker for keypad_scanner, attached by bind below.
// Assumes: it observes the top-level ports only.
module kp_scan_checker #(
    parameter int ROWS = 4,
    parameter int COLS = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [ROWS-1:0]      row_n_out,
    input logic [ROWS*COLS-1:0] key_map,
    input logic                 change_stb
);

    logic seen;

    // Marks that at least one clock has passed since reset was released.
    always_ff @(posedge clk) begin
        if (!rst_n)
            seen <= 1'b0;
        else
            seen <= 1'b1;
    end

    assert_reset_state_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !seen |-> (row_n_out == '1 && key_map == '0 && !change_stb));

    assert_one_row_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~row_n_out) <= 1);

    assert_next_row_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (seen && row_n_out != $past(row_n_out) && $past(row_n_out) != '1
              && $past(row_n_out[ROWS-1]))
        |-> ((~row_n_out) == ((~$past(row_n_out)) << 1)));

    assert_last_row_rests_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (seen && row_n_out != $past(row_n_out) && !$past(row_n_out[ROWS-1]))
        |-> (row_n_out == '1));

    assert_scan_starts_row0_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (seen && row_n_out != $past(row_n_out) && $past(row_n_out) == '1)
        |-> (row_n_out == {{(ROWS-1){1'b1}}, 1'b0}));

    assert_map_moves_on_sample_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (seen && key_map != $past(key_map)) |-> (row_n_out != $past(row_n_out)));

    assert_strobe_at_scan_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (seen && change_stb) |-> (row_n_out == '1 && !$past(row_n_out[ROWS-1])));

    assert_strobe_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        change_stb |=> !change_stb);

endmodule

bind keypad_scanner kp_scan_checker #(.ROWS(ROWS), .COLS(COLS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .row_n_out  (row_n_out),
    .key_map    (key_map),
    .change_stb (change_stb)
);

// File: tb/keypad_scanner_tb.sv
// Bench for keypad_scanner: models the switch matrix from the row drive
// and a pressed-key set, sweeps every key and checks timing and strobes.
module keypad_scanner_tb;

    localparam int CLK_PERIOD = 10;
    localparam int DIV        = 2;
    localparam int DWELL      = 3;
    localparam int GAP        = 2;
    localparam int DB         = 3;
    localparam int TIMEOUT    = 200000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  col_n;
    logic [3:0]  row_n;
    logic [15:0] key_map;
    logic        change_stb;
    logic [15:0] pressed = '0;

    int n_checks = 0;
    int n_fail   = 0;
    int stray_stb;
    bit timed_out = 0;
    bit end_stb;

    always #(CLK_PERIOD/2) clk = ~clk;

    keypad_scanner #(
        .ROWS(4), .COLS(4), .TICK_DIV(DIV),
        .DWELL_TICKS(DWELL), .GAP_TICKS(GAP), .DEBOUNCE(DB)
    ) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .col_n_in   (col_n),
        .row_n_out  (row_n),
        .key_map    (key_map),
        .change_stb (change_stb)
    );

    // Switch matrix model: a column reads low if a pressed key sits on a low row.
    always_comb begin
        for (int c = 0; c < 4; c++) begin
            col_n[c] = 1'b1;
            for (int r = 0; r < 4; r++)
                if (!row_n[r] && pressed[r*4 + c]) col_n[c] = 1'b0;
        end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // Wait for the negedge where rows return high after row 3; capture strobe.
    task automatic wait_scan_end();
        logic [3:0] prev = row_n;
        stray_stb = 0;
        forever begin
            @(negedge clk);
            if (prev == 4'b0111 && row_n == 4'b1111) begin
                end_stb = change_stb;
                break;
            end
            if (change_stb) stray_stb++;
            prev = row_n;
        end
    endtask

    // One scan; check map and strobe against expectations.
    task automatic scan_expect(input logic [15:0] exp_map, input bit exp_stb,
                               input string req);
        wait_scan_end();
        check(key_map == exp_map, req, key_map, exp_map);
        check(end_stb == exp_stb && stray_stb == 0, "R8 strobe",
              {end_stb, 15'd0, 16'(stray_stb)}, {exp_stb, 31'd0});
    endtask

    task automatic run_tests();
        int cnt;
        logic [3:0] exp_row;
        // R9 reset state
        repeat (3) @(negedge clk);
        check(row_n == 4'hF && key_map == 16'h0 && !change_stb, "R9 reset",
              {row_n, key_map, 11'd0, change_stb}, {4'hF, 28'd0});
        @(negedge clk);
        rst_n = 1'b1;
        wait_scan_end();

        // R2/R3/R4: gap length then each row's order and dwell length
        cnt = 1;
        @(negedge clk);
        while (row_n == 4'hF) begin cnt++; @(negedge clk); end
        check(cnt == GAP*DIV, "R4 gap cycles", cnt, GAP*DIV);
        for (int r = 0; r < 4; r++) begin
            exp_row = ~(4'b0001 << r);
            check(row_n == exp_row, "R2 row order", row_n, exp_row);
            check($countones(~row_n) == 1, "R1 single low row", row_n, exp_row);
            cnt = 0;
            while (row_n == exp_row) begin cnt++; @(negedge clk); end
            check(cnt == DWELL*DIV, "R3 dwell cycles", cnt, DWELL*DIV);
        end
        check(row_n == 4'hF, "R2 rest after last row", row_n, 4'hF);
        wait_scan_end();

        // R5/R6/R10: each key alone, press then release
        for (int k = 0; k < 16; k++) begin
            pressed = 16'(1) << k;
            for (int s = 1; s < DB; s++) scan_expect(16'h0, 1'b0, "R6 press early");
            scan_expect(16'(1) << k, 1'b1, "R5 R6 press lands");
            pressed = '0;
            for (int s = 1; s < DB; s++) scan_expect(16'(1) << k, 1'b0, "R10 release early");
            scan_expect(16'h0, 1'b1, "R10 release lands");
        end

        // R7: a bounced press restarts the run
        pressed = 16'h0020;
        scan_expect(16'h0, 1'b0, "R7 bounce run1");
        scan_expect(16'h0, 1'b0, "R7 bounce run2");
        pressed = '0;
        scan_expect(16'h0, 1'b0, "R7 bounce gap");
        pressed = 16'h0020;
        scan_expect(16'h0, 1'b0, "R7 rerun1");
        scan_expect(16'h0, 1'b0, "R7 rerun2");
        scan_expect(16'h0020, 1'b1, "R7 rerun lands");

        // R11: several keys, then inversion in one step
        pressed = 16'hA5C3;
        scan_expect(16'h0020, 1'b0, "R11 multi1");
        scan_expect(16'h0020, 1'b0, "R11 multi2");
        scan_expect(16'hA5C3, 1'b1, "R11 multi lands");
        pressed = 16'h5A3C;
        scan_expect(16'hA5C3, 1'b0, "R11 invert1");
        scan_expect(16'hA5C3, 1'b0, "R11 invert2");
        scan_expect(16'h5A3C, 1'b1, "R11 invert lands");

        // R8: stable inputs give no strobe
        for (int s = 0; s < 3; s++) scan_expect(16'h5A3C, 1'b0, "R8 quiet scan");
    endtask

    initial begin
        fork
            run_tests();
            begin
                repeat (TIMEOUT) @(posedge clk);
                timed_out = 1;
            end
        join_any
        disable fork;
        if (timed_out) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
        end
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule